// File: doc/BRIEF.md
# Packet-to-register transaction converter

This block turns framed request packets into word accesses on a simple 32-bit memory-mapped master port. It then frames the outcome as a response packet. Requests arrive one byte per beat on a valid/ready stream that carries start-of-packet and end-of-packet flags. Escaping, idle filtering and the serial link are handled upstream, so each byte seen here is already packet payload. Every request opens with an eight-byte header. Writes carry their data words after the header.

Each header names an operation: a single write, an incrementing write, a single read, an incrementing read, or a no-op. A write answers with a four-byte header that reports how many bytes were written. A read answers with the raw data words and no header. Only one request is in flight at a time. The input stream is held off until the current response has been fully sent. Both streams follow the usual rules. A byte moves on a clock edge where valid and ready are both high. Once raised, the output's valid, data and flags stay unchanged until ready is seen. The input side may stall between bytes for any number of cycles.

Top module: `xt_pkt_txn`

## Requirements
- R1: A request header is eight bytes, in this order: the operation code, one ignored byte, a 16-bit byte count sent high byte first, and a 32-bit address sent high byte first. Its first byte is flagged start-of-packet.
- R2: Code 0x00 writes one word at the header address. Write data words follow the header, each sent least-significant byte first.
- R3: A write response is four bytes: the request code with bit 7 set, a 0x00 byte, then the number of bytes actually written as a 16-bit value, high byte first. The first byte is flagged start-of-packet and the last end-of-packet.
- R4: A read response has no header. It holds only the read words, each sent least-significant byte first, with start-of-packet on its first byte and end-of-packet on its last.
- R5: Codes 0x04 (write) and 0x14 (read) access byte-count/4 words, with the address rising by 4 after each word.
- R6: The single codes 0x00 and 0x10 make exactly one bus access whatever the byte count. Surplus write data in the packet is discarded.
- R7: If a write packet ends before the byte count is covered, only the complete words received are written. The response reports that reduced count.
- R8: Code 0x7F makes no bus access and answers with the bytes 0xFF, 0x00, 0x00, 0x00.
- R9: A packet with any other code, a packet that ends inside its header, and an incrementing read with a byte count below 4 are all dropped. None of them makes a bus access or produces a response.
- R10: From the end of a request header until the last response byte is accepted, the input is not ready. A stalled output byte holds its data and flags.
- R11: A bus request and its address and data stay asserted while the wait input is high. Read and write are never asserted together, and a new read is not issued until the previous one has returned data.
- R12: Bytes that arrive outside a packet are ignored. A start-of-packet inside a header restarts header collection. Bytes after a complete read header, up to end-of-packet, are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Request byte accepted when high with in_valid |
| in_data | input | 8 | Request byte |
| in_sop | input | 1 | Request byte is the first of its packet |
| in_eop | input | 1 | Request byte is the last of its packet |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Response byte taken when high with out_valid |
| out_data | output | 8 | Response byte |
| out_sop | output | 1 | Response byte is the first of its packet |
| out_eop | output | 1 | Response byte is the last of its packet |
| mm_addr | output | 32 | Bus byte address |
| mm_rd | output | 1 | Bus read request |
| mm_wr | output | 1 | Bus write request |
| mm_wdata | output | 32 | Bus write data |
| mm_wait | input | 1 | Bus stall; a request completes in a cycle where this is low |
| mm_rdata | input | 32 | Bus read data |
| mm_rvalid | input | 1 | Bus read data valid |

## Verification
The cycle-level properties are checked on every cycle. These cover the bus handshake (a held request, exclusive read and write, one read outstanding), output stability under back-pressure, and the input being held off while a response is pending. Frame contents can only be shown by the scenarios, which compare every response byte against a reference memory and count bus accesses. That covers byte order, the count field, address stepping, discarded surplus data, truncated writes, and dropped packets.

// File: rtl/xt_pkg.sv
package xt_pkg;
  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_SEQ = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_SEQ = 8'h14;
  localparam logic [7:0] OP_NOP    = 8'h7F;
  localparam logic [7:0] RESP_FLAG = 8'h80;

  typedef enum logic [1:0] {K_DROP, K_WRITE, K_READ, K_NOP} op_kind_t;

  typedef enum logic [2:0] {
    ST_HDR, ST_SKIP, ST_WDAT, ST_WR, ST_RD, ST_RWAIT, ST_RDAT, ST_RESP
  } xt_state_t;
endpackage

// File: rtl/xt_op_decode.sv
module xt_op_decode
  import xt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BYTES = 4
) (
  input  logic [7:0]       code,
  input  logic [CNT_W-1:0] nbytes,
  output op_kind_t         kind,
  output logic             seq,
  output logic [CNT_W-1:0] nwords
);
  localparam int SH = $clog2(BYTES);

  always_comb begin
    kind = K_DROP;
    seq  = 1'b0;
    unique case (code)
      OP_WR:     kind = K_WRITE;
      OP_WR_SEQ: begin kind = K_WRITE; seq = 1'b1; end
      OP_RD:     kind = K_READ;
      OP_RD_SEQ: begin kind = K_READ; seq = 1'b1; end
      OP_NOP:    kind = K_NOP;
      default:   kind = K_DROP;
    endcase
    nwords = seq ? (nbytes >> SH) : CNT_W'(1);
  end
endmodule

// File: rtl/xt_word_pack.sv
module xt_word_pack #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] word,
  output logic               last
);
  localparam int IW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [IW-1:0] idx;

  assign last = (idx == IW'(BYTES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (push)   idx <= last ? '0 : idx + 1'b1;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word[8*g +: 8] <= '0;
      else if (push && idx == IW'(g))      word[8*g +: 8] <= din;
    end
  end
endmodule

// File: rtl/xt_resp_mux.sv
module xt_resp_mux
  import xt_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int CNT_W  = 16,
  parameter int OIDX_W = 2
) (
  input  logic               is_hdr,
  input  logic [OIDX_W-1:0]  idx,
  input  logic [7:0]         code,
  input  logic [CNT_W-1:0]   nbytes,
  input  logic [8*BYTES-1:0] rword,
  output logic [7:0]         dout
);
  localparam int RESP_BYTES = 2 + CNT_W/8;

  logic [8*RESP_BYTES-1:0] hvec;
  logic [7:0] hb, db;

  assign hvec = {code | RESP_FLAG, 8'h00, nbytes};

  always_comb begin
    hb = '0;
    db = '0;
    for (int k = 0; k < RESP_BYTES; k++)
      if (idx == OIDX_W'(k)) hb = hvec[8*(RESP_BYTES-1-k) +: 8];
    for (int k = 0; k < BYTES; k++)
      if (idx == OIDX_W'(k)) db = rword[8*k +: 8];
    dout = is_hdr ? hb : db;
  end
endmodule

// File: rtl/xt_pkt_txn.sv
module xt_pkt_txn
  import xt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [ADDR_W-1:0] mm_addr,
  output logic              mm_rd,
  output logic              mm_wr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic              mm_wait,
  input  logic [DATA_W-1:0] mm_rdata,
  input  logic              mm_rvalid
);
  localparam int BYTES      = DATA_W / 8;
  localparam int HDR_BYTES  = 2 + CNT_W/8 + ADDR_W/8;
  localparam int HDR_W      = 8 * HDR_BYTES;
  localparam int HC_W       = $clog2(HDR_BYTES + 1);
  localparam int RESP_BYTES = 2 + CNT_W/8;
  localparam int OMAX       = (BYTES > RESP_BYTES) ? BYTES : RESP_BYTES;
  localparam int OIDX_W     = $clog2(OMAX);
  localparam int SH         = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

  xt_state_t st, skip_to;
  logic              in_pkt;
  logic [HC_W-1:0]   hdr_cnt;
  logic [HDR_W-17:0] hdr_sr;     // code, count, address; reserved byte not kept
  logic [HDR_W-9:0]  full;
  logic [7:0]        code_q;
  logic [ADDR_W-1:0] addr_q;
  logic              seq_q, wr_end, first_q;
  logic [CNT_W-1:0]  words_left, done_cnt;
  logic [OIDX_W-1:0] oidx;
  logic [DATA_W-1:0] rd_word;

  logic              acc, hdr_done, pk_push, pk_last;
  logic [DATA_W-1:0] pk_word;
  op_kind_t          dec_kind;
  logic              dec_seq;
  logic [CNT_W-1:0]  dec_words;
  logic [HC_W-1:0]   byte_pos;

  assign in_ready = (st == ST_HDR) || (st == ST_SKIP) || (st == ST_WDAT);
  assign acc      = in_valid && in_ready;
  assign full     = {hdr_sr, in_data};
  assign byte_pos = in_sop ? '0 : hdr_cnt;
  assign hdr_done = acc && (st == ST_HDR) && !in_sop && in_pkt &&
                    (hdr_cnt == HC_W'(HDR_BYTES-1));
  assign pk_push  = acc && (st == ST_WDAT);

  xt_op_decode #(.CNT_W(CNT_W), .BYTES(BYTES)) u_dec (
    .code   (full[HDR_W-9 -: 8]),
    .nbytes (full[ADDR_W +: CNT_W]),
    .kind   (dec_kind),
    .seq    (dec_seq),
    .nwords (dec_words)
  );

  xt_word_pack #(.BYTES(BYTES)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hdr_done),
    .push  (pk_push),
    .din   (in_data),
    .word  (pk_word),
    .last  (pk_last)
  );

  xt_resp_mux #(.BYTES(BYTES), .CNT_W(CNT_W), .OIDX_W(OIDX_W)) u_mux (
    .is_hdr (st == ST_RESP),
    .idx    (oidx),
    .code   (code_q),
    .nbytes (done_cnt << SH),
    .rword  (rd_word),
    .dout   (out_data)
  );

  assign mm_addr   = addr_q;
  assign mm_wdata  = pk_word;
  assign mm_wr     = (st == ST_WR);
  assign mm_rd     = (st == ST_RD);
  assign out_valid = (st == ST_RDAT) || (st == ST_RESP);
  assign out_sop   = out_valid && (oidx == '0) && ((st == ST_RESP) || first_q);
  assign out_eop   = (st == ST_RESP) ? (oidx == OIDX_W'(RESP_BYTES-1)) :
                     (st == ST_RDAT) && (oidx == OIDX_W'(BYTES-1)) &&
                     (words_left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HDR;
      skip_to    <= ST_HDR;
      in_pkt     <= 1'b0;
      hdr_cnt    <= '0;
      hdr_sr     <= '0;
      code_q     <= '0;
      addr_q     <= '0;
      seq_q      <= 1'b0;
      wr_end     <= 1'b0;
      first_q    <= 1'b0;
      words_left <= '0;
      done_cnt   <= '0;
      oidx       <= '0;
      rd_word    <= '0;
    end else begin
      unique case (st)
        ST_HDR: begin
          if (acc && (in_sop || in_pkt)) begin
            if (byte_pos != HC_W'(1)) hdr_sr <= {hdr_sr[HDR_W-25:0], in_data};
            if (hdr_done) begin
              in_pkt     <= 1'b0;
              code_q     <= full[HDR_W-9 -: 8];
              addr_q     <= full[ADDR_W-1:0];
              seq_q      <= dec_seq;
              words_left <= dec_words;
              done_cnt   <= '0;
              first_q    <= 1'b1;
              oidx       <= '0;
              unique case (dec_kind)
                K_WRITE: st <= in_eop ? ST_RESP : ST_WDAT;
                K_READ: begin
                  if (dec_words == '0) begin
                    skip_to <= ST_HDR;
                    st      <= in_eop ? ST_HDR : ST_SKIP;
                  end else begin
                    skip_to <= ST_RD;
                    st      <= in_eop ? ST_RD : ST_SKIP;
                  end
                end
                K_NOP: begin
                  skip_to <= ST_RESP;
                  st      <= in_eop ? ST_RESP : ST_SKIP;
                end
                default: begin
                  skip_to <= ST_HDR;
                  st      <= in_eop ? ST_HDR : ST_SKIP;
                end
              endcase
            end else begin
              hdr_cnt <= byte_pos + 1'b1;
              in_pkt  <= !in_eop;
            end
          end
        end
        ST_SKIP: begin
          if (acc && in_eop) st <= skip_to;
        end
        ST_WDAT: begin
          if (acc) begin
            if (pk_last && (words_left != '0)) begin
              wr_end <= in_eop;
              st     <= ST_WR;
            end else if (in_eop) begin
              st <= ST_RESP;
            end
          end
        end
        ST_WR: begin
          if (!mm_wait) begin
            done_cnt   <= done_cnt + 1'b1;
            words_left <= words_left - 1'b1;
            if (seq_q) addr_q <= addr_q + STEP;
            st <= wr_end ? ST_RESP : ST_WDAT;
          end
        end
        ST_RD: begin
          if (!mm_wait) st <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mm_rvalid) begin
            rd_word <= mm_rdata;
            oidx    <= '0;
            st      <= ST_RDAT;
          end
        end
        ST_RDAT: begin
          if (out_ready) begin
            if (oidx == OIDX_W'(BYTES-1)) begin
              oidx       <= '0;
              first_q    <= 1'b0;
              words_left <= words_left - 1'b1;
              if (seq_q) addr_q <= addr_q + STEP;
              st <= (words_left == CNT_W'(1)) ? ST_HDR : ST_RD;
            end else begin
              oidx <= oidx + 1'b1;
            end
          end
        end
        ST_RESP: begin
          if (out_ready) begin
            if (oidx == OIDX_W'(RESP_BYTES-1)) begin
              oidx <= '0;
              st   <= ST_HDR;
            end else begin
              oidx <= oidx + 1'b1;
            end
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/xt_pkt_txn_chk.sv
module xt_pkt_txn_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_rd,
  input logic              mm_wr,
  input logic [DATA_W-1:0] mm_wdata,
  input logic              mm_wait,
  input logic              mm_rvalid
);
  logic rd_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rd_open <= 1'b0;
    else if (mm_rd && !mm_wait)   rd_open <= 1'b1;
    else if (mm_rvalid)           rd_open <= 1'b0;
  end

  // R11: requests never overlap
  assert_rw_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_rd && mm_wr));

  // R11: stalled write holds address and data
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_wr && mm_wait) |=> (mm_wr && $stable(mm_addr) && $stable(mm_wdata)));

  // R11: stalled read holds its address
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd && mm_wait) |=> (mm_rd && $stable(mm_addr)));

  // R11: one read outstanding
  assert_one_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mm_rd |-> !rd_open);

  // R10: stalled output byte is stable
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R10: no intake while a response is pending
  assert_no_intake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R4: frame flags only on valid bytes
  assert_flags_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);
endmodule

bind xt_pkt_txn xt_pkt_txn_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .mm_addr   (mm_addr),
  .mm_rd     (mm_rd),
  .mm_wr     (mm_wr),
  .mm_wdata  (mm_wdata),
  .mm_wait   (mm_wait),
  .mm_rvalid (mm_rvalid)
);

// File: tb/sim_xt_pkt_txn.sv
module sim_xt_pkt_txn;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_sop, out_eop;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [31:0] mm_addr, mm_wdata;
  logic        mm_rd, mm_wr;
  logic        mm_wait = 1'b0, mm_rvalid = 1'b0;
  logic [31:0] mm_rdata = '0;

  always #2 clk = ~clk;

  xt_pkt_txn u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .mm_wait(mm_wait), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid)
  );

  int checks = 0, fails = 0, cyc = 0, bus_n = 0, pend = 0;
  bit done = 1'b0;
  logic [31:0] bmem [0:63];
  logic [31:0] ref_mem [0:63];
  logic [31:0] rd_addr = '0;
  logic [9:0]  eq [$];
  string       tq [$];
  logic [9:0]  pq [$];

  function automatic logic [31:0] initv(int i);
    return 32'hC0DE_0000 ^ (i * 32'h0001_0203);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // bus model: wait pattern, write store, read with two-cycle latency
  always @(negedge clk) begin
    cyc++;
    mm_rvalid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin mm_rvalid = 1'b1; mm_rdata = bmem[rd_addr[7:2]]; end
    end
    mm_wait = (cyc % 3 == 1);
    if (rst_n && mm_wr && !mm_wait) begin bmem[mm_addr[7:2]] = mm_wdata; bus_n++; end
    if (rst_n && mm_rd && !mm_wait) begin rd_addr = mm_addr; pend = 2; bus_n++; end
  end

  // monitor: back-pressure pattern and scoreboard compare
  always @(negedge clk) begin
    out_ready = (cyc % 4 != 2);
    if (rst_n && out_valid && out_ready) begin
      if (eq.size() == 0) begin
        chk(1'b0, "R9", "unexpected output byte", {out_sop, out_eop, out_data}, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = eq.pop_front();
        t = tq.pop_front();
        chk({out_sop, out_eop, out_data} == e, t, "response byte {sop,eop,data}",
            {out_sop, out_eop, out_data}, e);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic hdr(input [7:0] c, input [15:0] n, input [31:0] a);
    pq.push_back({2'b00, c}); pq.push_back(10'h0);
    pq.push_back({2'b00, n[15:8]}); pq.push_back({2'b00, n[7:0]});
    pq.push_back({2'b00, a[31:24]}); pq.push_back({2'b00, a[23:16]});
    pq.push_back({2'b00, a[15:8]}); pq.push_back({2'b00, a[7:0]});
  endtask

  task automatic word(input [31:0] w);
    for (int b = 0; b < 4; b++) pq.push_back({2'b00, w[8*b +: 8]});
  endtask

  task automatic send(input bit frame);
    for (int i = 0; i < pq.size(); i++) begin
      in_valid = 1'b1;
      in_data  = pq[i][7:0];
      in_sop   = pq[i][9] | (frame && i == 0);
      in_eop   = pq[i][8] | (frame && i == pq.size() - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    pq.delete();
  endtask

  task automatic expb(input [7:0] b, input bit s, input bit e, input string t);
    eq.push_back({s, e, b});
    tq.push_back(t);
  endtask

  task automatic exp_wr(input [7:0] c, input [15:0] n, input string t);
    expb(c | 8'h80, 1, 0, t); expb(8'h00, 0, 0, t);
    expb(n[15:8], 0, 0, t);   expb(n[7:0], 0, 1, t);
  endtask

  task automatic exp_rd(input [31:0] a, input int n, input string t);
    for (int w = 0; w < n; w++) begin
      logic [31:0] v;
      v = ref_mem[a[7:2] + w];
      for (int b = 0; b < 4; b++) expb(v[8*b +: 8], w == 0 && b == 0, w == n-1 && b == 3, t);
    end
  endtask

  task automatic settle();
    while (!(eq.size() == 0 && in_ready && !out_valid && !mm_rd && !mm_wr)) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(eq.size() == 0, "R10", "pending expected bytes", eq.size(), 0);
  endtask

  initial begin
    int b0;
    for (int i = 0; i < 64; i++) begin bmem[i] = initv(i); ref_mem[i] = initv(i); end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
    chk(!mm_rd && !mm_wr, "R11", "reset bus idle", {mm_rd, mm_wr}, 0);

    // R2 R3: single write
    b0 = bus_n;
    hdr(8'h00, 16'd4, 32'h10); word(32'hA1B2C3D4);
    ref_mem[4] = 32'hA1B2C3D4;
    exp_wr(8'h00, 16'd4, "R3");
    send(1); settle();
    chk(bus_n == b0 + 1, "R2", "single write accesses", bus_n - b0, 1);

    // R4 R1: single read back, LSB first
    hdr(8'h10, 16'd4, 32'h10);
    exp_rd(32'h10, 1, "R4");
    send(1); settle();

    // R5: incrementing write of three words
    b0 = bus_n;
    hdr(8'h04, 16'd12, 32'h20);
    word(32'h11223344); word(32'h7A7B7C7D); word(32'h4A4D0080);
    ref_mem[8] = 32'h11223344; ref_mem[9] = 32'h7A7B7C7D; ref_mem[10] = 32'h4A4D0080;
    exp_wr(8'h04, 16'd12, "R5");
    send(1); settle();
    chk(bus_n == b0 + 3, "R5", "seq write accesses", bus_n - b0, 3);

    // R5: incrementing read of four words straddling the written block
    b0 = bus_n;
    hdr(8'h14, 16'd16, 32'h1C);
    exp_rd(32'h1C, 4, "R5");
    send(1); settle();
    chk(bus_n == b0 + 4, "R5", "seq read accesses", bus_n - b0, 4);

    // R8: no-op
    b0 = bus_n;
    hdr(8'h7F, 16'd0, 32'h0);
    expb(8'hFF, 1, 0, "R8"); expb(8'h00, 0, 0, "R8");
    expb(8'h00, 0, 0, "R8"); expb(8'h00, 0, 1, "R8");
    send(1); settle();
    chk(bus_n == b0, "R8", "no-op accesses", bus_n - b0, 0);

    // R9: unknown code dropped
    b0 = bus_n;
    hdr(8'h33, 16'd4, 32'h10); word(32'h0);
    send(1); settle();
    chk(bus_n == b0, "R9", "unknown code accesses", bus_n - b0, 0);

    // R9: header cut short
    b0 = bus_n;
    hdr(8'h00, 16'd4, 32'h10);
    repeat (3) void'(pq.pop_back());
    send(1); settle();
    chk(bus_n == b0, "R9", "truncated header accesses", bus_n - b0, 0);

    // R9: incrementing read with zero count
    b0 = bus_n;
    hdr(8'h14, 16'd0, 32'h10);
    send(1); settle();
    chk(bus_n == b0, "R9", "zero-count read accesses", bus_n - b0, 0);

    // R6: single write with surplus data
    b0 = bus_n;
    hdr(8'h00, 16'd8, 32'h40); word(32'hDEADBEEF); word(32'h01020304);
    ref_mem[16] = 32'hDEADBEEF;
    exp_wr(8'h00, 16'd4, "R6");
    send(1); settle();
    chk(bus_n == b0 + 1, "R6", "single write accesses", bus_n - b0, 1);
    hdr(8'h14, 16'd8, 32'h40);
    exp_rd(32'h40, 2, "R6");
    send(1); settle();

    // R6: single read with large count
    b0 = bus_n;
    hdr(8'h10, 16'd64, 32'h08);
    exp_rd(32'h08, 1, "R6");
    send(1); settle();
    chk(bus_n == b0 + 1, "R6", "single read accesses", bus_n - b0, 1);

    // R7: write ends early with a partial word
    b0 = bus_n;
    hdr(8'h04, 16'd8, 32'h50); word(32'h55667788);
    pq.push_back(10'h0AA); pq.push_back(10'h0BB);
    ref_mem[20] = 32'h55667788;
    exp_wr(8'h04, 16'd4, "R7");
    send(1); settle();
    chk(bus_n == b0 + 1, "R7", "short write accesses", bus_n - b0, 1);
    hdr(8'h14, 16'd8, 32'h50);
    exp_rd(32'h50, 2, "R7");
    send(1); settle();

    // R12: stray bytes, restart on sop, trailing junk after read header
    pq.push_back(10'h012); pq.push_back(10'h010);
    send(0);
    pq.push_back(10'h210); pq.push_back(10'h000); pq.push_back(10'h000);
    hdr(8'h10, 16'd4, 32'h24);
    pq[3][9] = 1'b1;
    pq.push_back(10'h099); pq.push_back(10'h098);
    exp_rd(32'h24, 1, "R12");
    send(1); settle();

    // R1: address bytes carried high first
    hdr(8'h10, 16'd4, 32'h0000_00FC);
    exp_rd(32'hFC, 1, "R1");
    send(1); settle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule